// File: doc/BRIEF.md
# Bus-Matching Write Packer

This block sits between a write port whose active width may be 36, 18 or 9 bits and the write side of a storage array that only accepts whole 36-bit long words. Each accepted port write supplies one piece, which is a long word, a word or a byte. Pieces that do not yet make a full long word are kept in per-lane holding registers. The long word goes to storage in the same clock edge that brings in its final piece. On that edge the storage write strobe is high and the assembled word is on the storage data output.

The long word is split into four 9-bit lanes. The order in which a word's pieces fill those lanes comes from an endian select input. If the bus size or the endian select differs from the previous accepted write, the packing sequence restarts. Any pieces already held are then dropped, and the write that caused the change becomes the first piece of a new long word. While storage reports full, port writes are turned away and the packing state does not change.

Top module: `bus_pack_writer`

## Requirements
- R1: Size select encoding is 00 = long word, 01 = word, 10 = byte, and 11 behaves as long word. While reset (rst_n low) is asserted, the storage write strobe stays low whatever the port inputs are.
- R2: In long-word mode every accepted write raises st_wr in the same cycle, with st_data equal to wr_data.
- R3: In word mode the first word is held without a storage write, and the second word raises st_wr. With little endian (big_endian = 0) the first word fills bits 0–17 and the second fills bits 18–35.
- R4: In byte mode the first three bytes are held, and the fourth raises st_wr. With little endian, byte k fills bits 9k to 9k+8.
- R5: With big_endian = 1 the first piece fills the most significant lanes: in word mode the first word goes to bits 18–35, and in byte mode the first byte goes to bits 27–35.
- R6: An accepted write whose bus size or endian select differs from the previous accepted write drops all held pieces and counts as the first piece of a new long word.
- R7: While st_full is high, a port write is rejected. st_wr stays low and the partial long word and piece count are left as they were.
- R8: st_wr is high only in a cycle with wr_en high, and only for a write that completes a long word.
- R9: In word mode only wr_data bits 0–17 are used, and in byte mode only bits 0–8 are used. The remaining input bits never reach st_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Port-side write request |
| bus_size | input | 2 | Piece size: 00 long, 01 word, 10 byte, 11 long |
| big_endian | input | 1 | 1: first piece fills the most significant lanes |
| wr_data | input | 36 | Port-side write data, with pieces taken from the low bits |
| st_full | input | 1 | Storage full flag |
| st_wr | output | 1 | Storage write strobe, high in the cycle a long word completes |
| st_data | output | 36 | Assembled long word presented to storage |

## Verification
Two functions can land on the same edge: a mode change that resets packing, and the completion of a long word. The bench sets up the case where the write that changes the size is also the only piece of a long word, and the case where a size change is followed by a complete word. The scoreboard then expects exactly the newly written data and no stale held lane. A second case puts a full flag on the write that would otherwise complete a word. The next write after the flag drops must still complete that same word.

// File: rtl/bpw_pkg.sv
// Package: shared encodings and helpers for the bus-matching write packer.
// Assumes a long word made of an even number of equal lanes.
package bpw_pkg;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_WORD = 2'b01,
        SZ_BYTE = 2'b10,
        SZ_RSVD = 2'b11
    } bus_size_e;

    // Number of port pieces that make up one long word for a size code.
    function automatic int pieces_of(input logic [1:0] sz, input int lanes);
        case (sz)
            SZ_WORD: return 2;
            SZ_BYTE: return lanes;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/bpw_lane_map.sv
// Lane mapper: for the current piece index, decides which lanes of the
// long word the incoming piece fills and routes the piece's low bits there.
// Assumes idx is below the piece count for the given size.
module bpw_lane_map #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    parameter int IDX_W  = 2
) (
    input  logic [1:0]              size,
    input  logic                    big_end,
    input  logic [IDX_W-1:0]        idx,
    input  logic [LANES*LANE_W-1:0] data,
    output logic [LANES-1:0]        lane_en,
    output logic [LANES*LANE_W-1:0] placed
);
    int lpp;

    // Lanes covered by one piece for the selected size.
    always_comb lpp = LANES / bpw_pkg::pieces_of(size, LANES);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        int grp;
        int sub;
        // Piece number owning this lane, counted from the endian-selected end.
        assign grp = big_end ? (LANES - 1 - l) / lpp : l / lpp;
        // Position of this lane inside its piece.
        assign sub = l % lpp;
        assign lane_en[l] = (grp == int'(idx));
        assign placed[l*LANE_W +: LANE_W] = data[sub*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/bpw_seq.sv
// Packing sequencer: tracks how many pieces of the current long word have
// been accepted and the mode (size, endian) they used. A mode change makes
// the incoming piece index zero. Assumes accept is already gated by reset.
module bpw_seq #(
    parameter int LANES = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [1:0]       size,
    input  logic             big_end,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    logic [IDX_W-1:0] cnt_q;
    logic [2:0]       mode_q;
    logic             mode_vld_q;
    logic             same_mode;

    // Effective index: restart at zero when the mode differs from the last write.
    always_comb begin
        same_mode = mode_vld_q && (mode_q == {size, big_end});
        idx       = same_mode ? cnt_q : '0;
        last      = (int'(idx) == bpw_pkg::pieces_of(size, LANES) - 1);
    end

    // Advance or wrap the piece counter and remember the mode on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            mode_q     <= '0;
            mode_vld_q <= 1'b0;
        end else if (accept) begin
            cnt_q      <= last ? '0 : idx + 1'b1;
            mode_q     <= {size, big_end};
            mode_vld_q <= 1'b1;
        end
    end

endmodule

// File: rtl/bus_pack_writer.sv
// Bus-matching write packer top: collects long-word, word or byte pieces
// into 36-bit long words and strobes storage on the edge that brings the
// final piece. Assumes storage captures st_data on the clock edge where
// st_wr is high; writes are refused while st_full is high.
module bus_pack_writer #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [1:0]              bus_size,
    input  logic                    big_endian,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    st_full,
    output logic                    st_wr,
    output logic [LANES*LANE_W-1:0] st_data
);
    localparam int WORD_W = LANES * LANE_W;
    localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1;

    logic              accept;
    logic              last;
    logic [IDX_W-1:0]  idx;
    logic [LANES-1:0]  lane_en;
    logic [WORD_W-1:0] placed;
    logic [LANE_W-1:0] held_q [LANES];

    // A write is taken only outside reset and while storage has room.
    assign accept = rst_n && wr_en && !st_full;
    assign st_wr  = accept && last;

    bpw_seq #(.LANES(LANES), .IDX_W(IDX_W)) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .size    (bus_size),
        .big_end (big_endian),
        .idx     (idx),
        .last    (last)
    );

    bpw_lane_map #(.LANE_W(LANE_W), .LANES(LANES), .IDX_W(IDX_W)) i_map (
        .size    (bus_size),
        .big_end (big_endian),
        .idx     (idx),
        .data    (wr_data),
        .lane_en (lane_en),
        .placed  (placed)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_hold
        // Keep a lane filled by a non-final piece until the word completes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                held_q[l] <= '0;
            else if (accept && !last && lane_en[l])
                held_q[l] <= placed[l*LANE_W +: LANE_W];
        end
        // Output lane: the incoming piece overrides the held value.
        assign st_data[l*LANE_W +: LANE_W] =
            lane_en[l] ? placed[l*LANE_W +: LANE_W] : held_q[l];
    end

endmodule

// File: rtl/bpw_chk.sv
// Checker for bus_pack_writer: port-level properties on the storage strobe.
// Attached to every instance of the top module by the bind below.
module bpw_chk #(
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        bus_size,
    input logic              big_endian,
    input logic [WORD_W-1:0] wr_data,
    input logic              st_full,
    input logic              st_wr,
    input logic [WORD_W-1:0] st_data
);
    logic acc_word;
    logic acc_byte;

    assign acc_word = wr_en && !st_full && (bus_size == 2'b01);
    assign acc_byte = wr_en && !st_full && (bus_size == 2'b10);

    // R7
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_full |-> !st_wr);

    // R8
    strobe_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !st_wr);

    // R2
    long_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !st_full && bus_size == 2'b00) |-> (st_wr && st_data == wr_data));

    // R3
    word_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_word && st_wr) |=>
            !(acc_word && big_endian == $past(big_endian) && st_wr));

    // R4
    byte_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_byte && st_wr) |=>
            !(acc_byte && big_endian == $past(big_endian) && st_wr));

endmodule

bind bus_pack_writer bpw_chk #(.WORD_W(LANES*LANE_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .bus_size   (bus_size),
    .big_endian (big_endian),
    .wr_data    (wr_data),
    .st_full    (st_full),
    .st_wr      (st_wr),
    .st_data    (st_data)
);

// File: tb/test_bus_pack_writer.sv
module test_bus_pack_writer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  bus_size = 2'b00;
    logic        big_endian = 1'b0;
    logic [35:0] wr_data = '0;
    logic        st_full = 1'b0;
    logic        st_wr;
    logic [35:0] st_data;

    int checks = 0;
    int errors = 0;

    logic [35:0] exp_q[$];
    string       tag_q[$];

    bus_pack_writer i_bus_pack_writer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bus_size(bus_size),
        .big_endian(big_endian), .wr_data(wr_data), .st_full(st_full),
        .st_wr(st_wr), .st_data(st_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: every storage write is compared with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && st_wr) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected storage write: actual %h expected none", st_data);
            end else begin
                automatic logic [35:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (st_data !== e) begin
                    errors++;
                    $display("FAIL %s st_data actual %h expected %h", t, st_data, e);
                end
            end
        end
    end

    // Driver: one port write, checks the strobe and queues the expected word.
    task automatic drive(input logic [1:0] sz, input logic be, input logic [35:0] d,
                         input logic full, input logic exp_wr,
                         input logic [35:0] exp_w, input string tag);
        @(posedge clk); #1;
        wr_en = 1'b1; bus_size = sz; big_endian = be; wr_data = d; st_full = full;
        if (exp_wr) begin
            exp_q.push_back(exp_w);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        checks++;
        if (st_wr !== exp_wr) begin
            errors++;
            $display("FAIL %s st_wr actual %b expected %b", tag, st_wr, exp_wr);
        end
    endtask

    task automatic idle(input logic [35:0] d);
        @(posedge clk); #1;
        wr_en = 1'b0; st_full = 1'b0; wr_data = d;
        @(negedge clk);
        checks++;
        if (st_wr !== 1'b0) begin
            errors++;
            $display("FAIL R8 idle st_wr actual %b expected 0", st_wr);
        end
    endtask

    localparam logic [26:0] JB = 27'h5555555;
    localparam logic [17:0] JW = 18'h3FFFF;

    initial begin
        logic [8:0]  b0, b1, b2, b3;
        logic [17:0] w0, w1;
        b0 = 9'h1A1; b1 = 9'h0B2; b2 = 9'h1C3; b3 = 9'h0D4;
        w0 = 18'h21234; w1 = 18'h1ABCD;

        // R1: reset holds the strobe low even with a long-word request.
        wr_en = 1'b1; bus_size = 2'b00; wr_data = 36'h123456789;
        @(negedge clk);
        checks++;
        if (st_wr !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset st_wr actual %b expected 0", st_wr);
        end
        @(posedge clk); #1;
        rst_n = 1'b1; wr_en = 1'b0;

        // R2: long words go straight through; R1: code 11 acts as long word.
        drive(2'b00, 1'b0, 36'hABCDE1234, 1'b0, 1'b1, 36'hABCDE1234, "R2");
        drive(2'b00, 1'b1, 36'h0F0F0F0F0, 1'b0, 1'b1, 36'h0F0F0F0F0, "R2");
        drive(2'b11, 1'b0, 36'h876543210, 1'b0, 1'b1, 36'h876543210, "R1");

        // R3/R9: word little endian, junk in upper input bits.
        drive(2'b01, 1'b0, {JW, w0}, 1'b0, 1'b0, '0, "R3");
        drive(2'b01, 1'b0, {JW, w1}, 1'b0, 1'b1, {w1, w0}, "R3 R9");

        // R5: word big endian.
        drive(2'b01, 1'b1, {JW, w0}, 1'b0, 1'b0, '0, "R5");
        drive(2'b01, 1'b1, {JW, w1}, 1'b0, 1'b1, {w0, w1}, "R5");

        // R4/R9: byte little endian.
        drive(2'b10, 1'b0, {JB, b0}, 1'b0, 1'b0, '0, "R4");
        drive(2'b10, 1'b0, {JB, b1}, 1'b0, 1'b0, '0, "R4");
        drive(2'b10, 1'b0, {JB, b2}, 1'b0, 1'b0, '0, "R4");
        drive(2'b10, 1'b0, {JB, b3}, 1'b0, 1'b1, {b3, b2, b1, b0}, "R4 R9");

        // R5: byte big endian.
        drive(2'b10, 1'b1, {JB, b0}, 1'b0, 1'b0, '0, "R5");
        drive(2'b10, 1'b1, {JB, b1}, 1'b0, 1'b0, '0, "R5");
        drive(2'b10, 1'b1, {JB, b2}, 1'b0, 1'b0, '0, "R5");
        drive(2'b10, 1'b1, {JB, b3}, 1'b0, 1'b1, {b0, b1, b2, b3}, "R5");

        // R6: bytes dropped by a switch to word mode.
        drive(2'b10, 1'b0, {JB, b0}, 1'b0, 1'b0, '0, "R6");
        drive(2'b10, 1'b0, {JB, b1}, 1'b0, 1'b0, '0, "R6");
        drive(2'b01, 1'b0, {JW, w0}, 1'b0, 1'b0, '0, "R6");
        drive(2'b01, 1'b0, {JW, w1}, 1'b0, 1'b1, {w1, w0}, "R6");

        // R6: held word dropped by a long write that commits at once.
        drive(2'b01, 1'b0, {JW, w0}, 1'b0, 1'b0, '0, "R6");
        drive(2'b00, 1'b0, 36'h13579BDF0, 1'b0, 1'b1, 36'h13579BDF0, "R6");

        // R6: endian change also restarts packing.
        drive(2'b01, 1'b0, {JW, w1}, 1'b0, 1'b0, '0, "R6");
        drive(2'b01, 1'b1, {JW, w0}, 1'b0, 1'b0, '0, "R6");
        drive(2'b01, 1'b1, {JW, w1}, 1'b0, 1'b1, {w0, w1}, "R6");

        // R7: full blocks a partial write and a completing write; state kept.
        drive(2'b10, 1'b0, {JB, b0}, 1'b0, 1'b0, '0, "R7");
        drive(2'b10, 1'b0, {JB, 9'h1FF}, 1'b1, 1'b0, '0, "R7");
        drive(2'b10, 1'b0, {JB, b1}, 1'b0, 1'b0, '0, "R7");
        drive(2'b10, 1'b0, {JB, b2}, 1'b0, 1'b0, '0, "R7");
        drive(2'b10, 1'b0, {JB, 9'h000}, 1'b1, 1'b0, '0, "R7");
        drive(2'b01, 1'b1, {JW, w0}, 1'b1, 1'b0, '0, "R7");
        drive(2'b10, 1'b0, {JB, b3}, 1'b0, 1'b1, {b3, b2, b1, b0}, "R7");

        // R8: idle cycles with changing data never write.
        idle(36'hFFFFFFFFF);
        drive(2'b01, 1'b0, {JW, w1}, 1'b0, 1'b0, '0, "R8");
        idle(36'h000000000);
        drive(2'b01, 1'b0, {JW, w0}, 1'b0, 1'b1, {w0, w1}, "R8");
        idle('0);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 missing storage writes: actual %0d pending expected 0", exp_q.size());
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule